// File: doc/BRIEF.md
# Per-Source Interrupt Pending Logic

This block holds one pending flag for each interrupt input of a local interrupt controller. A 2-bit trigger field per source, set at run time, picks how the flag behaves. In level mode the flag is a live copy of the input. In the two edge modes, rising or falling, the flag is a latch. A detected transition sets it. Software can set or clear it. The hardware clears it when the core takes that interrupt.

The register bank forwards software writes as a one-cycle strobe with a source ID and a value. The core reports a taken interrupt as a one-cycle pulse with the ID it accepted. The pending vector feeds the arbiter and the read-back path. Input synchronisation, enables and arbitration are handled outside this block.

Top module: `irq_pend_top`

## Requirements
- R1: When bit 0 of a source's trigger field is 0 (codes 2'b00 and 2'b10), that source's pending output equals its input in the same cycle, with no register in the path.
- R2: In level mode, a software write of either value to the source has no effect on its pending output.
- R3: With trigger code 2'b01, an input sampled high at a clock edge after being sampled low at the previous edge sets the pending flag, visible right after that edge.
- R4: With trigger code 2'b11, an input sampled low after being sampled high sets the pending flag at that edge.
- R5: In either edge mode, a software write with value 1 sets the addressed flag and a write with value 0 clears it, both visible after the next clock edge.
- R6: In an edge mode, a take pulse clears the flag of the source whose ID it carries. Every other flag is left alone.
- R7: If a detected edge and a clear (software write 0 or take) hit the same source in the same cycle, the flag ends up set. A software set combined with a take also leaves it set.
- R8: Reset (rst_ni low, asynchronous) clears every latched flag and every stored previous input sample. An input that is already high when reset is released therefore counts as a rising edge at the first clock edge.
- R9: Switching a set flag between rising and falling mode keeps it set. While a source is in level mode its latch is held cleared, so on a return to an edge mode the flag starts at 0.
- R10: A software write or take whose ID is not a source's own, or whose ID is not below NUM_SRC, leaves that source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC | Interrupt inputs, already synchronous to clk_i |
| trig_i | input | NUM_SRC x 2 | Trigger field per source: bit 0 = edge mode, bit 1 = falling when in edge mode |
| sw_we_i | input | 1 | Software pending write strobe |
| sw_id_i | input | ID_W | Source addressed by the write |
| sw_val_i | input | 1 | Value written to the pending flag |
| take_i | input | 1 | One-cycle pulse: the core has taken an interrupt |
| take_id_i | input | ID_W | Source being taken |
| pend_o | output | NUM_SRC | Pending vector |

## Verification
The assertions assume that irq_i is already synchronous to clk_i, and that take_i and sw_we_i are single-cycle strobes whose ID fields are stable while they are high. The edge and hold checks compare against the detector's own stored sample, so they stay correct in the first cycle after reset. The bench changes every input only at the falling clock edge and drops both strobes after one cycle. Trigger fields change only between steps, never together with the edge they are meant to catch. The reference model in the bench replays each rising edge with the same inputs the design sees.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic [1:0] {
    TRIG_LEVEL   = 2'b00,
    TRIG_RISE    = 2'b01,
    TRIG_LEVEL_B = 2'b10,
    TRIG_FALL    = 2'b11
  } trig_e;

  function automatic logic trig_is_edge(logic [1:0] t);
    return t[0];
  endfunction

  function automatic logic trig_is_fall(logic [1:0] t);
    return t[1];
  endfunction
endpackage

// File: rtl/irq_id_decode.sv
module irq_id_decode #(
  parameter int N    = 8,
  parameter int ID_W = 3
) (
  input  logic            valid_i,
  input  logic [ID_W-1:0] id_i,
  output logic [N-1:0]    hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign hit_o[g] = valid_i && (id_i == ID_W'(g));
  end
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign edge_o = fall_sel_i ? (prev_q & ~sig_i) : (~prev_q & sig_i);
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
  import irq_pend_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic [1:0] trig_i,
  input  logic       sw_hit_i,
  input  logic       sw_val_i,
  input  logic       take_hit_i,
  output logic       pend_o
);
  logic edge_w;
  logic edge_mode;
  logic set_w;
  logic clr_w;
  logic latch_q;

  assign edge_mode = trig_is_edge(trig_i);

  irq_edge_det u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sig_i      (irq_i),
    .fall_sel_i (trig_is_fall(trig_i)),
    .edge_o     (edge_w)
  );

  assign set_w = edge_w | (sw_hit_i & sw_val_i);
  assign clr_w = (sw_hit_i & ~sw_val_i) | take_hit_i;

  // set has priority over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        latch_q <= 1'b0;
    else if (!edge_mode) latch_q <= 1'b0;
    else if (set_w)      latch_q <= 1'b1;
    else if (clr_w)      latch_q <= 1'b0;
  end

  assign pend_o = edge_mode ? latch_q : irq_i;

  assert_level_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode && $fell(irq_i)) |-> !pend_o);

  assert_level_wr_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode && sw_hit_i && sw_val_i && !irq_i) |-> !pend_o);

  assert_edge_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && edge_w) |=> (!edge_mode || pend_o));

  assert_take_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && take_hit_i && !edge_w && !sw_hit_i) |=> (!edge_mode || !pend_o));

  assert_edge_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && !edge_w && !sw_hit_i && !take_hit_i) |=> (!edge_mode || $stable(pend_o)));
endmodule

// File: rtl/irq_pend_top.sv
module irq_pend_top #(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_SRC-1:0]      irq_i,
  input  logic [NUM_SRC-1:0][1:0] trig_i,
  input  logic                    sw_we_i,
  input  logic [ID_W-1:0]         sw_id_i,
  input  logic                    sw_val_i,
  input  logic                    take_i,
  input  logic [ID_W-1:0]         take_id_i,
  output logic [NUM_SRC-1:0]      pend_o
);
  logic [NUM_SRC-1:0] sw_hit;
  logic [NUM_SRC-1:0] take_hit;

  irq_id_decode #(.N(NUM_SRC), .ID_W(ID_W)) u_sw_dec (
    .valid_i (sw_we_i),
    .id_i    (sw_id_i),
    .hit_o   (sw_hit)
  );

  irq_id_decode #(.N(NUM_SRC), .ID_W(ID_W)) u_take_dec (
    .valid_i (take_i),
    .id_i    (take_id_i),
    .hit_o   (take_hit)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_pend_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .irq_i      (irq_i[g]),
      .trig_i     (trig_i[g]),
      .sw_hit_i   (sw_hit[g]),
      .sw_val_i   (sw_val_i),
      .take_hit_i (take_hit[g]),
      .pend_o     (pend_o[g])
    );
  end

  assert_one_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take_hit));

  assert_one_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sw_hit));
endmodule

// File: tb/irq_pend_top_bench.sv
module irq_pend_top_bench;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic [N-1:0][1:0] trig = '0;
  logic sw_we = 1'b0, sw_val = 1'b0, take = 1'b0;
  logic [IW-1:0] sw_id = '0, take_id = '0;
  logic [N-1:0] pend;

  always #2.5 clk = ~clk;

  irq_pend_top #(.NUM_SRC(N)) u_irq_pend_top (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .trig_i(trig),
    .sw_we_i(sw_we), .sw_id_i(sw_id), .sw_val_i(sw_val),
    .take_i(take), .take_id_i(take_id), .pend_o(pend)
  );

  typedef struct { logic [N-1:0] exp; string tag; } item_t;
  item_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [N-1:0] m_latch = '0, m_prev = '0;

  function automatic logic [N-1:0] model_out();
    logic [N-1:0] o;
    for (int i = 0; i < N; i++) o[i] = trig[i][0] ? m_latch[i] : irq[i];
    return o;
  endfunction

  function automatic void model_clock();
    for (int i = 0; i < N; i++) begin
      logic ed, swh, tkh;
      ed  = trig[i][1] ? (m_prev[i] & ~irq[i]) : (~m_prev[i] & irq[i]);
      swh = sw_we && (int'(sw_id) == i);
      tkh = take && (int'(take_id) == i);
      if (!trig[i][0])               m_latch[i] = 1'b0;
      else if (ed || (swh && sw_val)) m_latch[i] = 1'b1;
      else if ((swh && !sw_val) || tkh) m_latch[i] = 1'b0;
    end
    m_prev = irq;
  endfunction

  task automatic check_now(string tag);
    n_cmp++;
    if (pend !== model_out()) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, pend, model_out());
    end
  endtask

  // driver: inputs already set after a negedge
  task automatic step(string tag);
    item_t it;
    model_clock();
    @(posedge clk);
    #1;
    it.exp = model_out();
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    sw_we = 1'b0;
    take  = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        n_cmp++;
        if (pend !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, pend, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("R8 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 level mirror, same cycle
    irq = 8'hA5; #1;
    check_now("R1 level mirror comb");
    trig[6] = 2'b10;
    step("R1 level mirror reg");
    irq[6] = 1'b1; #1;
    check_now("R1 code 2'b10 is level");
    step("R1 level hold");

    // R2 writes ignored in level mode
    sw_we = 1; sw_id = 0; sw_val = 0;
    step("R2 write 0 ignored");
    sw_we = 1; sw_id = 1; sw_val = 1;
    step("R2 write 1 ignored");

    // R3 rising edge, bit 2 currently high
    trig[2] = 2'b01;
    step("R9 enter edge mode from level starts clear");
    irq[2] = 0; step("R3 low no set");
    irq[2] = 1; step("R3 rising sets");
    irq[2] = 0; step("R3 stays set on fall");

    // R4 falling edge on bit 3
    trig[3] = 2'b11;
    irq[3] = 1; step("R4 rise ignored in fall mode");
    irq[3] = 0; step("R4 falling sets");

    // R6 take clears only the addressed source
    take = 1; take_id = 2;
    step("R6 take clears id 2 only");

    // R5 software set and clear in edge mode
    trig[4] = 2'b01;
    step("R5 prep");
    sw_we = 1; sw_id = 4; sw_val = 1;
    step("R5 sw set");
    sw_we = 1; sw_id = 4; sw_val = 0;
    step("R5 sw clear");
    sw_we = 1; sw_id = 3; sw_val = 1;
    step("R10 sw set id 3, id 4 untouched");

    // R7 edge beats take and sw clear
    irq[2] = 1; take = 1; take_id = 2;
    step("R7 edge beats take");
    irq[3] = 1; step("R7 prep");
    irq[3] = 0; sw_we = 1; sw_id = 3; sw_val = 0;
    step("R7 edge beats sw clear");
    sw_we = 1; sw_id = 4; sw_val = 1; take = 1; take_id = 4;
    step("R7 sw set beats take");
    take = 1; take_id = 5;
    step("R10 take of other id no effect");

    // R9 mode changes
    trig[3] = 2'b01;
    step("R9 fall to rise keeps set");
    trig[3] = 2'b00; #1;
    check_now("R9 to level mirrors input");
    step("R9 level latch cleared");
    trig[3] = 2'b11;
    step("R9 back to edge starts clear");

    // R8 input high across reset release
    trig[6] = 2'b01; irq[6] = 1;
    step("R8 prep");
    rst_n = 0; #1;
    m_latch = '0; m_prev = '0;
    check_now("R8 async reset clears latches");
    @(negedge clk);
    rst_n = 1;
    step("R8 high input after reset is an edge");
    step("R8 hold");

    done = 1;
    #5;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule